// File: doc/BRIEF.md
# Rolling-Priority Output Link Scheduler

This block schedules packets onto one outgoing link that runs in fixed slots. Each slot, one packet leaves. Several connections share a small buffer. Each connection is given a phase when it is set up. Every connection then runs through epochs of a fixed length of `RATE_N * FRAME_T` slots, shifted by its phase.

In each slot the scheduler sends a packet from the connection whose current epoch began longest ago. This is the connection with the greatest epoch age, where age = (slot counter − phase) mod epoch length. Because every age wraps at the end of its epoch, the priority order rotates over time. Each connection leads in turn, and the scheduler needs no state beyond its own slot counter and buffer.

When arrivals overflow the buffer, the scheduler uses the same order in reverse to pick the packet to discard. Connection-setup packets are marked and are never discarded. Up to `NUM_IN` packets may arrive in one slot.

Top module: `epoch_link_sched`

## Requirements
- R1: A synchronous active-low reset empties the buffer, zeroes the slot counter and clears every output. In the first cycle after reset, `tx_valid_o` and all `drop_valid_o` bits are 0.
- R2: The slot counter starts at 0 on the first clock edge after reset and advances by one per edge, modulo the epoch length. At each edge the scheduler transmits a packet of the buffered connection with the largest age, where age = (counter − phase) mod epoch length. Connection c takes its phase from `phase_i[c*AGE_W +: AGE_W]`.
- R3: When two buffered connections have equal age, the lower connection number is transmitted first.
- R4: Packets of one connection leave in arrival order. Within one slot, lane 0 counts as arriving before lane 1.
- R5: `tx_valid_o` is 1 after an edge exactly when the buffer held at least one packet before that edge. A packet that arrives at an edge can leave at the next edge at the earliest.
- R6: A drop is reported only when, at one edge, the packets already held (less the one transmitted) plus the arrivals would exceed `BUF_DEPTH`. Filling the buffer exactly causes no drop.
- R7: On overflow, the discarded packet comes from the candidate connection with the smallest age. Equal ages are broken by the higher connection number. Within that connection the newest packet is discarded, which may be the arriving one. The discard is reported on the lane of the arrival that caused it: `drop_conn_o[l*CONN_W +: CONN_W]` and `drop_tag_o[l*TAG_W +: TAG_W]`.
- R8: A packet whose `arr_init_i` bit is 1 is never chosen for discard. It is kept and transmitted later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one slot per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_i | input | NUM_CONN*AGE_W | Per-connection epoch phase, each below the epoch length |
| arr_valid_i | input | NUM_IN | Arrival present on each lane |
| arr_conn_i | input | NUM_IN*CONN_W | Connection number of each arrival |
| arr_tag_i | input | NUM_IN*TAG_W | Packet tag of each arrival |
| arr_init_i | input | NUM_IN | Arrival is a connection-setup packet |
| tx_valid_o | output | 1 | A packet was sent in the last slot |
| tx_conn_o | output | CONN_W | Connection of the sent packet |
| tx_tag_o | output | TAG_W | Tag of the sent packet |
| drop_valid_o | output | NUM_IN | A packet was discarded because of this lane's arrival |
| drop_conn_o | output | NUM_IN*CONN_W | Connection of each discarded packet |
| drop_tag_o | output | NUM_IN*TAG_W | Tag of each discarded packet |

## Verification
The bench uses the default build: four connections, an eight-slot epoch (RATE_N 2, FRAME_T 4), a four-entry buffer and two arrival lanes. With only four entries, two arrivals in one slot overflow a full buffer in a few cycles. This lets the bench reach all three overflow cases: the arriving packet is dropped, a stored packet is evicted, and a setup packet is protected. With an eight-slot epoch and spread phases, the leading connection changes within a handful of slots, so the rotation and the age ties can be checked by hand.

// File: rtl/eps_pkg.sv
// Shared definitions for the rolling-priority link scheduler.
// Assumes ages and connection numbers fit in 32-bit unsigned integers.
package eps_pkg;

    // Outcome of one overflow decision for one arrival lane
    typedef enum logic [1:0] {
        VIC_NONE    = 2'd0,
        VIC_ARRIVAL = 2'd1,
        VIC_STORED  = 2'd2
    } victim_e;

    // True when (a_age, a_conn) has strictly higher link priority than (b_age, b_conn)
    function automatic logic outranks(input int unsigned a_age, input int unsigned a_conn,
                                      input int unsigned b_age, input int unsigned b_conn);
        return (a_age > b_age) || ((a_age == b_age) && (a_conn < b_conn));
    endfunction

endpackage

// File: rtl/eps_slot_ages.sv
// Slot counter and per-connection epoch age.
// The counter wraps at EPOCH_LEN. Each connection's age is
// (counter - phase) mod EPOCH_LEN. Assumes every phase is below EPOCH_LEN.
module eps_slot_ages #(
    parameter int NUM_CONN  = 4,
    parameter int EPOCH_LEN = 8,
    parameter int AGE_W     = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CONN*AGE_W-1:0] phase_i,
    output logic [NUM_CONN*AGE_W-1:0] age_o
);
    localparam logic [AGE_W-1:0] LAST_SLOT = AGE_W'(EPOCH_LEN - 1);
    localparam logic [AGE_W-1:0] LEN_TRUNC = AGE_W'(EPOCH_LEN);

    logic [AGE_W-1:0] slot_q;

    // Advance the slot counter once per edge, wrapping at the epoch length
    always_ff @(posedge clk) begin
        if (!rst_n)                  slot_q <= '0;
        else if (slot_q == LAST_SLOT) slot_q <= '0;
        else                         slot_q <= slot_q + 1'b1;
    end

    for (genvar g = 0; g < NUM_CONN; g++) begin : g_age
        logic [AGE_W-1:0] ph;
        logic [AGE_W-1:0] age_g;
        assign ph = phase_i[g*AGE_W +: AGE_W];

        // Modular distance from this connection's epoch start to the current slot
        always_comb begin
            if (slot_q >= ph) age_g = slot_q - ph;
            else              age_g = LEN_TRUNC + slot_q - ph;
        end

        assign age_o[g*AGE_W +: AGE_W] = age_g;
    end

endmodule

// File: rtl/eps_tx_pick.sv
// Chooses the stored entry to transmit: the highest-priority connection,
// then the oldest entry of that connection (the lowest index).
// Assumes the entries are kept in arrival order, index 0 oldest.
module eps_tx_pick #(
    parameter int DEPTH    = 4,
    parameter int NUM_CONN = 4,
    parameter int CONN_W   = 2,
    parameter int AGE_W    = 3,
    parameter int IDX_W    = 2
) (
    input  logic [DEPTH-1:0]          ent_valid_i,
    input  logic [DEPTH*CONN_W-1:0]   ent_conn_i,
    input  logic [NUM_CONN*AGE_W-1:0] age_i,
    output logic                      pick_valid_o,
    output logic [IDX_W-1:0]          pick_idx_o
);
    logic [AGE_W-1:0] age_a [NUM_CONN];

    for (genvar g = 0; g < NUM_CONN; g++) begin : g_unpack
        assign age_a[g] = age_i[g*AGE_W +: AGE_W];
    end

    // Scan from oldest to newest, replacing the choice only on strictly higher priority
    always_comb begin
        int unsigned best_age;
        int unsigned best_conn;
        int unsigned cur_age;
        logic [CONN_W-1:0] cur_conn;
        pick_valid_o = 1'b0;
        pick_idx_o   = '0;
        best_age     = 0;
        best_conn    = 0;
        for (int i = 0; i < DEPTH; i++) begin
            cur_conn = ent_conn_i[i*CONN_W +: CONN_W];
            cur_age  = int'(age_a[cur_conn]);
            if (ent_valid_i[i] &&
                (!pick_valid_o || eps_pkg::outranks(cur_age, int'(cur_conn), best_age, best_conn))) begin
                pick_valid_o = 1'b1;
                pick_idx_o   = IDX_W'(i);
                best_age     = cur_age;
                best_conn    = int'(cur_conn);
            end
        end
    end

endmodule

// File: rtl/eps_queue.sv
// Shared packet buffer kept as a compacted, arrival-ordered list.
// Each edge it removes the entry chosen for transmission, then takes in
// arrivals lane by lane. On overflow it discards the lowest-priority,
// newest non-setup candidate. Assumes the buffer never fills with setup
// packets alone (if it does, the arrival is discarded).
module eps_queue #(
    parameter int DEPTH    = 4,
    parameter int NUM_CONN = 4,
    parameter int NUM_IN   = 2,
    parameter int CONN_W   = 2,
    parameter int AGE_W    = 3,
    parameter int TAG_W    = 8,
    parameter int IDX_W    = 2,
    parameter int OCC_W    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CONN*AGE_W-1:0] age_i,
    input  logic [NUM_IN-1:0]         arr_valid_i,
    input  logic [NUM_IN*CONN_W-1:0]  arr_conn_i,
    input  logic [NUM_IN*TAG_W-1:0]   arr_tag_i,
    input  logic [NUM_IN-1:0]         arr_init_i,
    output logic [OCC_W-1:0]          occ_o,
    output logic                      head_valid_o,
    output logic [CONN_W-1:0]         head_conn_o,
    output logic [TAG_W-1:0]          head_tag_o,
    output logic [NUM_IN-1:0]         drop_valid_o,
    output logic [NUM_IN*CONN_W-1:0]  drop_conn_o,
    output logic [NUM_IN*TAG_W-1:0]   drop_tag_o
);
    import eps_pkg::*;

    logic [DEPTH-1:0]  v_q,    v_n;
    logic [CONN_W-1:0] conn_q [DEPTH];
    logic [CONN_W-1:0] conn_n [DEPTH];
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [TAG_W-1:0]  tag_n  [DEPTH];
    logic [DEPTH-1:0]  init_q, init_n;
    logic [OCC_W-1:0]  occ_q,  occ_n;

    logic [DEPTH*CONN_W-1:0] conn_flat;
    logic                    pick_valid;
    logic [IDX_W-1:0]        pick_idx;
    logic [AGE_W-1:0]        age_a [NUM_CONN];

    for (genvar g = 0; g < NUM_CONN; g++) begin : g_age_unpack
        assign age_a[g] = age_i[g*AGE_W +: AGE_W];
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_flat
        assign conn_flat[e*CONN_W +: CONN_W] = conn_q[e];
    end

    eps_tx_pick #(
        .DEPTH(DEPTH), .NUM_CONN(NUM_CONN), .CONN_W(CONN_W),
        .AGE_W(AGE_W), .IDX_W(IDX_W)
    ) u_pick (
        .ent_valid_i (v_q),
        .ent_conn_i  (conn_flat),
        .age_i       (age_i),
        .pick_valid_o(pick_valid),
        .pick_idx_o  (pick_idx)
    );

    // Present the entry chosen for this slot's transmission
    assign head_valid_o = pick_valid;
    assign head_conn_o  = conn_q[pick_idx];
    assign head_tag_o   = tag_q[pick_idx];
    assign occ_o        = occ_q;

    // Next buffer contents: remove the sent entry, then insert or discard per lane
    always_comb begin
        int               fill;
        int               vidx;
        int unsigned      vage;
        int unsigned      vconn;
        int unsigned      eage;
        logic             have;
        logic [CONN_W-1:0] ac;
        logic [TAG_W-1:0]  at;
        logic              ai;
        victim_e           kind;

        v_n    = v_q;
        conn_n = conn_q;
        tag_n  = tag_q;
        init_n = init_q;
        fill   = int'(occ_q);
        drop_valid_o = '0;
        drop_conn_o  = '0;
        drop_tag_o   = '0;
        vidx  = DEPTH;
        vage  = 0;
        vconn = 0;
        eage  = 0;
        have  = 1'b0;
        ac    = '0;
        at    = '0;
        ai    = 1'b0;
        kind  = VIC_NONE;

        if (pick_valid) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (i >= int'(pick_idx)) begin
                    v_n[i]    = v_n[i+1];
                    conn_n[i] = conn_n[i+1];
                    tag_n[i]  = tag_n[i+1];
                    init_n[i] = init_n[i+1];
                end
            end
            v_n[DEPTH-1]    = 1'b0;
            init_n[DEPTH-1] = 1'b0;
            fill = fill - 1;
        end

        for (int l = 0; l < NUM_IN; l++) begin
            if (arr_valid_i[l]) begin
                ac = arr_conn_i[l*CONN_W +: CONN_W];
                at = arr_tag_i[l*TAG_W +: TAG_W];
                ai = arr_init_i[l];
                if (fill < DEPTH) begin
                    v_n[IDX_W'(fill)]    = 1'b1;
                    conn_n[IDX_W'(fill)] = ac;
                    tag_n[IDX_W'(fill)]  = at;
                    init_n[IDX_W'(fill)] = ai;
                    fill = fill + 1;
                end else begin
                    // Arrival is the newest candidate; scan the rest newest first
                    have  = !ai;
                    vidx  = DEPTH;
                    vage  = int'(age_a[ac]);
                    vconn = int'(ac);
                    for (int i = DEPTH - 1; i >= 0; i--) begin
                        eage = int'(age_a[conn_n[i]]);
                        if (!init_n[i] &&
                            (!have || outranks(vage, vconn, eage, int'(conn_n[i])))) begin
                            have  = 1'b1;
                            vidx  = i;
                            vage  = eage;
                            vconn = int'(conn_n[i]);
                        end
                    end
                    kind = (vidx == DEPTH) ? VIC_ARRIVAL : VIC_STORED;
                    drop_valid_o[l] = 1'b1;
                    if (kind == VIC_ARRIVAL) begin
                        drop_conn_o[l*CONN_W +: CONN_W] = ac;
                        drop_tag_o[l*TAG_W +: TAG_W]    = at;
                    end else begin
                        drop_conn_o[l*CONN_W +: CONN_W] = conn_n[IDX_W'(vidx)];
                        drop_tag_o[l*TAG_W +: TAG_W]    = tag_n[IDX_W'(vidx)];
                        for (int i = 0; i < DEPTH - 1; i++) begin
                            if (i >= vidx) begin
                                conn_n[i] = conn_n[i+1];
                                tag_n[i]  = tag_n[i+1];
                                init_n[i] = init_n[i+1];
                            end
                        end
                        conn_n[DEPTH-1] = ac;
                        tag_n[DEPTH-1]  = at;
                        init_n[DEPTH-1] = ai;
                    end
                end
            end
        end
        occ_n = OCC_W'(fill);
    end

    // Register the buffer state at each slot edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q    <= '0;
            init_q <= '0;
            occ_q  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                conn_q[i] <= '0;
                tag_q[i]  <= '0;
            end
        end else begin
            v_q    <= v_n;
            init_q <= init_n;
            occ_q  <= occ_n;
            conn_q <= conn_n;
            tag_q  <= tag_n;
        end
    end

endmodule

// File: rtl/epoch_link_sched.sv
// Rolling-priority output link scheduler: one packet per slot, chosen by the
// largest epoch age; overflow discards by the reverse of that order.
// Assumes NUM_CONN >= 2, BUF_DEPTH >= 2 and every phase below the epoch length.
module epoch_link_sched #(
    parameter int NUM_CONN  = 4,
    parameter int RATE_N    = 2,
    parameter int FRAME_T   = 4,
    parameter int BUF_DEPTH = 4,
    parameter int NUM_IN    = 2,
    parameter int TAG_W     = 8,
    localparam int EPOCH_LEN = RATE_N * FRAME_T,
    localparam int AGE_W     = (EPOCH_LEN > 1) ? $clog2(EPOCH_LEN) : 1,
    localparam int CONN_W    = $clog2(NUM_CONN),
    localparam int IDX_W     = $clog2(BUF_DEPTH),
    localparam int OCC_W     = $clog2(BUF_DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CONN*AGE_W-1:0] phase_i,
    input  logic [NUM_IN-1:0]         arr_valid_i,
    input  logic [NUM_IN*CONN_W-1:0]  arr_conn_i,
    input  logic [NUM_IN*TAG_W-1:0]   arr_tag_i,
    input  logic [NUM_IN-1:0]         arr_init_i,
    output logic                      tx_valid_o,
    output logic [CONN_W-1:0]         tx_conn_o,
    output logic [TAG_W-1:0]          tx_tag_o,
    output logic [NUM_IN-1:0]         drop_valid_o,
    output logic [NUM_IN*CONN_W-1:0]  drop_conn_o,
    output logic [NUM_IN*TAG_W-1:0]   drop_tag_o
);
    logic [NUM_CONN*AGE_W-1:0] age_w;
    logic [OCC_W-1:0]          occ_w;
    logic                      head_valid;
    logic [CONN_W-1:0]         head_conn;
    logic [TAG_W-1:0]          head_tag;
    logic [NUM_IN-1:0]         drop_valid_n;
    logic [NUM_IN*CONN_W-1:0]  drop_conn_n;
    logic [NUM_IN*TAG_W-1:0]   drop_tag_n;

    eps_slot_ages #(
        .NUM_CONN(NUM_CONN), .EPOCH_LEN(EPOCH_LEN), .AGE_W(AGE_W)
    ) u_ages (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase_i(phase_i),
        .age_o  (age_w)
    );

    eps_queue #(
        .DEPTH(BUF_DEPTH), .NUM_CONN(NUM_CONN), .NUM_IN(NUM_IN), .CONN_W(CONN_W),
        .AGE_W(AGE_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .OCC_W(OCC_W)
    ) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .age_i       (age_w),
        .arr_valid_i (arr_valid_i),
        .arr_conn_i  (arr_conn_i),
        .arr_tag_i   (arr_tag_i),
        .arr_init_i  (arr_init_i),
        .occ_o       (occ_w),
        .head_valid_o(head_valid),
        .head_conn_o (head_conn),
        .head_tag_o  (head_tag),
        .drop_valid_o(drop_valid_n),
        .drop_conn_o (drop_conn_n),
        .drop_tag_o  (drop_tag_n)
    );

    // Register this slot's transmission and discard reports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid_o   <= 1'b0;
            tx_conn_o    <= '0;
            tx_tag_o     <= '0;
            drop_valid_o <= '0;
            drop_conn_o  <= '0;
            drop_tag_o   <= '0;
        end else begin
            tx_valid_o   <= head_valid;
            tx_conn_o    <= head_valid ? head_conn : '0;
            tx_tag_o     <= head_valid ? head_tag  : '0;
            drop_valid_o <= drop_valid_n;
            drop_conn_o  <= drop_conn_n;
            drop_tag_o   <= drop_tag_n;
        end
    end

endmodule

// File: rtl/eps_checker.sv
// Temporal checks on the scheduler's ports and buffer occupancy.
// Attached to every epoch_link_sched instance by the bind below.
module eps_checker #(
    parameter int DEPTH  = 4,
    parameter int NUM_IN = 2,
    parameter int OCC_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_IN-1:0] arr_valid_i,
    input logic [OCC_W-1:0]  occ_i,
    input logic              tx_valid_i,
    input logic [NUM_IN-1:0] drop_valid_i
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!tx_valid_i && drop_valid_i == '0 && occ_i == '0));

    // R5
    busy_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_i != '0) |=> tx_valid_i);

    // R5
    idle_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_i == '0) |=> !tx_valid_i);

    // R6
    occ_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (int'(occ_i) == int'($past(occ_i)) - int'($past(occ_i) != '0)
                          + $countones($past(arr_valid_i)) - $countones(drop_valid_i)));

    // R6
    drop_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && drop_valid_i != '0) |->
        (int'($past(occ_i)) - int'($past(occ_i) != '0) + $countones($past(arr_valid_i)) > DEPTH));

endmodule

bind epoch_link_sched eps_checker #(
    .DEPTH(BUF_DEPTH), .NUM_IN(NUM_IN), .OCC_W(OCC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .arr_valid_i (arr_valid_i),
    .occ_i       (occ_w),
    .tx_valid_i  (tx_valid_o),
    .drop_valid_i(drop_valid_o)
);

// File: tb/epoch_link_sched_bench.sv
// Directed bench: each task resets the block, drives one scenario and checks it.
module epoch_link_sched_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] phase = '0;
    logic [1:0]  arr_valid = '0;
    logic [3:0]  arr_conn = '0;
    logic [15:0] arr_tag = '0;
    logic [1:0]  arr_init = '0;
    logic        tx_valid;
    logic [1:0]  tx_conn;
    logic [7:0]  tx_tag;
    logic [1:0]  drop_valid;
    logic [3:0]  drop_conn;
    logic [15:0] drop_tag;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    epoch_link_sched u_epoch_link_sched (
        .clk(clk), .rst_n(rst_n), .phase_i(phase),
        .arr_valid_i(arr_valid), .arr_conn_i(arr_conn), .arr_tag_i(arr_tag), .arr_init_i(arr_init),
        .tx_valid_o(tx_valid), .tx_conn_o(tx_conn), .tx_tag_o(tx_tag),
        .drop_valid_o(drop_valid), .drop_conn_o(drop_conn), .drop_tag_o(drop_tag)
    );

    task automatic set_ph(input int p0, input int p1, input int p2, input int p3);
        phase = {3'(p3), 3'(p2), 3'(p1), 3'(p0)};
    endtask

    task automatic put(input int lane, input int c, input int t, input bit ini);
        arr_valid[lane]          = 1'b1;
        arr_conn[lane*2 +: 2]    = 2'(c);
        arr_tag[lane*8 +: 8]     = 8'(t);
        arr_init[lane]           = ini;
    endtask

    // One slot edge; returns at the following falling edge with arrivals cleared
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        arr_valid = '0; arr_conn = '0; arr_tag = '0; arr_init = '0;
    endtask

    task automatic chk_tx(input string req, input bit ev, input int ec, input int et);
        n_chk++;
        if (tx_valid !== ev || (ev && (int'(tx_conn) != ec || int'(tx_tag) != et))) begin
            n_fail++;
            $display("FAIL %s tx: got v=%0b c=%0d t=%h, want v=%0b c=%0d t=%h",
                     req, tx_valid, tx_conn, tx_tag, ev, ec, et[7:0]);
        end
    endtask

    task automatic chk_drop(input string req, input int lane, input bit ev, input int ec, input int et);
        n_chk++;
        if (drop_valid[lane] !== ev ||
            (ev && (int'(drop_conn[lane*2 +: 2]) != ec || int'(drop_tag[lane*8 +: 8]) != et))) begin
            n_fail++;
            $display("FAIL %s drop lane %0d: got v=%0b c=%0d t=%h, want v=%0b c=%0d t=%h",
                     req, lane, drop_valid[lane], drop_conn[lane*2 +: 2], drop_tag[lane*8 +: 8],
                     ev, ec, et[7:0]);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        // R1: outputs quiet after reset
        chk_tx("R1", 1'b0, 0, 0);
        chk_drop("R1", 0, 1'b0, 0, 0);
        chk_drop("R1", 1, 1'b0, 0, 0);
        rst_n = 1'b1;
    endtask

    // R2, R5: priority rotates with the slot counter
    task automatic t_rotation();
        set_ph(0, 3, 5, 7);
        do_reset();
        put(0, 0, 'h10, 0); put(1, 1, 'h11, 0); step();
        chk_tx("R5", 1'b0, 0, 0);
        put(0, 2, 'h12, 0); put(1, 3, 'h13, 0); step();
        chk_tx("R2", 1'b1, 1, 'h11);
        chk_drop("R6", 0, 1'b0, 0, 0);
        step(); chk_tx("R2", 1'b1, 2, 'h12);
        step(); chk_tx("R2", 1'b1, 3, 'h13);
        step(); chk_tx("R2", 1'b1, 0, 'h10);
        step(); chk_tx("R5", 1'b0, 0, 0);
    endtask

    // R3: equal ages go to the lower connection number
    task automatic t_tie();
        set_ph(0, 2, 0, 2);
        do_reset();
        put(0, 3, 'h31, 0); put(1, 1, 'h21, 0); step();
        step(); chk_tx("R3", 1'b1, 1, 'h21);
        step(); chk_tx("R3", 1'b1, 3, 'h31);
    endtask

    // R4: arrival order within a connection, lane 0 first
    task automatic t_fifo();
        set_ph(0, 0, 0, 0);
        do_reset();
        put(0, 2, 'h40, 0); put(1, 2, 'h41, 0); step();
        put(0, 2, 'h42, 0); step();
        chk_tx("R4", 1'b1, 2, 'h40);
        step(); chk_tx("R4", 1'b1, 2, 'h41);
        step(); chk_tx("R4", 1'b1, 2, 'h42);
    endtask

    // R6, R7: exact fill, arriving packet dropped, stored packet evicted
    task automatic t_overflow();
        set_ph(0, 1, 2, 3);
        do_reset();
        put(0, 0, 'hA0, 0); put(1, 0, 'hA1, 0); step();
        put(0, 0, 'hA2, 0); put(1, 0, 'hA3, 0); step();
        chk_tx("R2", 1'b1, 0, 'hA0);
        put(0, 3, 'hB0, 0); put(1, 3, 'hB1, 0); step();
        chk_tx("R4", 1'b1, 0, 'hA1);
        chk_drop("R6", 0, 1'b0, 0, 0);
        chk_drop("R6", 1, 1'b0, 0, 0);
        put(0, 3, 'hB2, 0); put(1, 3, 'hB3, 0); step();
        chk_tx("R2", 1'b1, 0, 'hA2);
        chk_drop("R6", 0, 1'b0, 0, 0);
        chk_drop("R7", 1, 1'b1, 3, 'hB3);
        put(0, 0, 'hA4, 0); put(1, 1, 'hC0, 0); step();
        chk_tx("R2", 1'b1, 0, 'hA3);
        chk_drop("R6", 0, 1'b0, 0, 0);
        chk_drop("R7", 1, 1'b1, 3, 'hB2);
        step(); chk_tx("R7", 1'b1, 0, 'hA4);
        step(); chk_tx("R7", 1'b1, 1, 'hC0);
        step(); chk_tx("R7", 1'b1, 3, 'hB0);
        step(); chk_tx("R7", 1'b1, 3, 'hB1);
        step(); chk_tx("R5", 1'b0, 0, 0);
    endtask

    // R8: setup packets are skipped when choosing the discard
    task automatic t_init_kept();
        set_ph(0, 1, 2, 3);
        do_reset();
        put(0, 3, 'h50, 0); put(1, 3, 'h51, 0); step();
        put(0, 3, 'h52, 0); put(1, 3, 'h53, 0); step();
        chk_tx("R2", 1'b1, 3, 'h50);
        put(0, 0, 'h60, 0); put(1, 0, 'h61, 0); step();
        chk_tx("R4", 1'b1, 3, 'h51);
        put(0, 3, 'h70, 1); put(1, 3, 'h71, 1); step();
        chk_tx("R2", 1'b1, 0, 'h60);
        chk_drop("R8", 0, 1'b0, 0, 0);
        chk_drop("R8", 1, 1'b1, 3, 'h53);
        step(); chk_tx("R8", 1'b1, 0, 'h61);
        step(); chk_tx("R8", 1'b1, 3, 'h52);
        step(); chk_tx("R8", 1'b1, 3, 'h70);
        step(); chk_tx("R8", 1'b1, 3, 'h71);
        step(); chk_tx("R5", 1'b0, 0, 0);
    endtask

    initial begin
        @(negedge clk);
        t_rotation();
        t_tie();
        t_fifo();
        t_overflow();
        t_init_kept();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got no finish, want finish within 5000 cycles");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule